// File: doc/BRIEF.md
# Bus-Idle Sleep and Wake Controller

This block decides when a bus node drops into its low-power sleep state and when it comes back out. In normal operation it counts idle bit times on the bus and puts the node to sleep after a long quiet stretch, provided automatic sleep is enabled. A second entry route puts the node to sleep at power-up. When power-up sleep is configured, the node starts in listen-only mode. It sleeps at the first bit strobe, but only if no bus activity has been seen since reset.

While asleep, the controller watches three wake sources and merges them: an external reset request, a GPIO change on a pin whose own interrupt enable is set, and bus activity. A wake raises a one-cycle pulse, which a reset sequencer can use to start its oscillator settling count. If bus activity caused the wake, an acknowledge-suppress flag tells the protocol engine to neither receive nor acknowledge that frame. A node that slept from power-up returns to listen-only mode. It enters normal mode only after a valid message that is not the suppressed waking frame. During sleep, peripheral enables are dropped and the I/O state is frozen.

Top module: `bus_sleep_ctrl`

## Requirements
- R1: While reset is high, sleep_o, listen_o, wake_o, ack_sup_o and io_hold_o are 0 and every bit of periph_en_o is 1.
- R2: In normal mode with sleep_en_i set, sleep_o rises at the clock edge that samples the IDLE_BITS-th (default 1408) consecutive bit strobe without bus activity.
- R3: With sleep_en_i clear, normal mode never enters sleep, and the idle count saturates at IDLE_BITS. Setting sleep_en_i after saturation gives sleep at the next edge that sees no bus activity.
- R4: Any cycle with bus_act_i high in normal mode clears the idle count, so a fresh run of IDLE_BITS idle strobes is needed.
- R5: If pu_sleep_en_i is high at reset, listen_o is 1 one cycle after reset drops. The first bit strobe with no bus activity since reset then gives sleep. If pu_sleep_en_i is low, the controller goes to normal mode instead.
- R6: After a wake from power-up sleep, listen_o stays 1 until msg_valid_i is seen while ack_sup_o is 0. listen_o then drops to 0 (normal mode).
- R7: In sleep, an external request, an enabled GPIO change or bus activity ends sleep at the next edge, and wake_o is high for exactly that one cycle.
- R8: A GPIO change whose bit in gpio_ie_i is 0 does not end sleep.
- R9: ack_sup_o rises with the wake only when bus_act_i caused it, and stays 1 until frame_end_i is sampled. An external or GPIO wake leaves it at 0.
- R10: io_hold_o equals sleep_o in every cycle.
- R11: During sleep, all five enable bits of periph_en_o are 0; otherwise all are 1.
- R12: Bus activity in listen-only mode before the first sleep cancels power-up sleep, so later idle strobes do not cause sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en_i | input | 1 | Allows automatic sleep after the idle timeout |
| pu_sleep_en_i | input | 1 | Selects listen-only start with power-up sleep |
| bit_tick_i | input | 1 | One-cycle strobe per bus bit time |
| bus_act_i | input | 1 | Bus activity seen in this cycle |
| ext_wake_i | input | 1 | External reset request (wake source) |
| gpio_chg_i | input | N_GPIO | Per-pin change flags |
| gpio_ie_i | input | N_GPIO | Per-pin interrupt enables |
| msg_valid_i | input | 1 | Protocol engine confirms a valid message |
| frame_end_i | input | 1 | Protocol engine reports end of a frame |
| sleep_o | output | 1 | Node is asleep |
| listen_o | output | 1 | Node is in listen-only mode |
| periph_en_o | output | 5 | Enables: bit0 A/D, bit1 auto-conversion, bit2 auto-messaging, bit3 PWM, bit4 clock output |
| io_hold_o | output | 1 | Freeze I/O pin state |
| wake_o | output | 1 | One-cycle wake pulse |
| ack_sup_o | output | 1 | Do not receive or acknowledge the current frame |

## Verification
A wrong idle count shows as sleep_o rising one or more strobes early or late against the 1408-strobe boundary. A count that is not cleared shows up at the first activity-interrupted run. A stale power-up flag sends a woken node to the wrong mode, and listen_o shows this in the cycle after the wake. A lost or stuck suppress flag lets the waking frame's msg_valid_i promote the node too early, and that is visible on listen_o within one cycle. Every output is compared against a reference model at every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/bus_sleep_pkg.sv
package bus_sleep_pkg;

    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_NORMAL = 2'd1,
        ST_LISTEN = 2'd2,
        ST_SLEEP  = 2'd3
    } sleep_state_e;

    typedef struct packed {
        logic ext;
        logic gpio;
        logic bus;
    } wake_src_t;

    localparam int NUM_GATES    = 5;
    localparam int GATE_ADC     = 0;
    localparam int GATE_AUTOCNV = 1;
    localparam int GATE_AUTOMSG = 2;
    localparam int GATE_PWM     = 3;
    localparam int GATE_CLKOUT  = 4;

    function automatic logic any_wake(input wake_src_t s);
        return s.ext | s.gpio | s.bus;
    endfunction

endpackage

// File: rtl/bus_sleep_idle_count.sv
module bus_sleep_idle_count #(
    parameter int IDLE_BITS = 1408
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic act,
    output logic limit_hit
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_BITS);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || act) begin
            cnt_d = '0;
        end else if (tick && cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign limit_hit = run && !act && (cnt_d == LIMIT);

endmodule

// File: rtl/bus_sleep_wake_merge.sv
module bus_sleep_wake_merge
    import bus_sleep_pkg::*;
#(
    parameter int N_GPIO = 8
) (
    input  logic              ext_req,
    input  logic              bus_act,
    input  logic [N_GPIO-1:0] chg,
    input  logic [N_GPIO-1:0] ie,
    output wake_src_t         src
);
    logic [N_GPIO-1:0] pin_wake;

    for (genvar g = 0; g < N_GPIO; g++) begin : g_pin
        assign pin_wake[g] = chg[g] & ie[g];
    end

    always_comb begin
        src.ext  = ext_req;
        src.gpio = |pin_wake;
        src.bus  = bus_act;
    end

endmodule

// File: rtl/bus_sleep_fsm.sv
module bus_sleep_fsm
    import bus_sleep_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         sleep_en,
    input  logic         pu_sleep_en,
    input  logic         tick,
    input  logic         bus_act,
    input  logic         idle_done,
    input  wake_src_t    src,
    input  logic         msg_valid,
    input  logic         frame_end,
    output sleep_state_e state,
    output logic         wake_pulse,
    output logic         ack_sup
);
    sleep_state_e st_q, st_d;
    logic armed_q, armed_d;
    logic pu_slept_q, pu_slept_d;
    logic ack_q, ack_d;
    logic wake_q, wake_d;
    logic waking;

    assign waking = (st_q == ST_SLEEP) && any_wake(src);

    always_comb begin
        st_d       = st_q;
        armed_d    = armed_q;
        pu_slept_d = pu_slept_q;
        case (st_q)
            ST_INIT: begin
                st_d    = pu_sleep_en ? ST_LISTEN : ST_NORMAL;
                armed_d = pu_sleep_en;
            end
            ST_NORMAL: begin
                if (sleep_en && idle_done) begin
                    st_d = ST_SLEEP;
                end
            end
            ST_LISTEN: begin
                if (msg_valid && !ack_q) begin
                    st_d       = ST_NORMAL;
                    armed_d    = 1'b0;
                    pu_slept_d = 1'b0;
                end else if (armed_q && bus_act) begin
                    armed_d = 1'b0;
                end else if (armed_q && tick) begin
                    st_d       = ST_SLEEP;
                    armed_d    = 1'b0;
                    pu_slept_d = 1'b1;
                end
            end
            default: begin
                if (waking) begin
                    st_d = pu_slept_q ? ST_LISTEN : ST_NORMAL;
                end
            end
        endcase
    end

    always_comb begin
        wake_d = waking;
        ack_d  = ack_q;
        if (waking && src.bus) begin
            ack_d = 1'b1;
        end else if (frame_end) begin
            ack_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_INIT;
            armed_q    <= 1'b0;
            pu_slept_q <= 1'b0;
            ack_q      <= 1'b0;
            wake_q     <= 1'b0;
        end else begin
            st_q       <= st_d;
            armed_q    <= armed_d;
            pu_slept_q <= pu_slept_d;
            ack_q      <= ack_d;
            wake_q     <= wake_d;
        end
    end

    assign state      = st_q;
    assign wake_pulse = wake_q;
    assign ack_sup    = ack_q;

endmodule

// File: rtl/bus_sleep_ctrl.sv
module bus_sleep_ctrl
    import bus_sleep_pkg::*;
#(
    parameter int IDLE_BITS = 1408,
    parameter int N_GPIO    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sleep_en_i,
    input  logic                 pu_sleep_en_i,
    input  logic                 bit_tick_i,
    input  logic                 bus_act_i,
    input  logic                 ext_wake_i,
    input  logic [N_GPIO-1:0]    gpio_chg_i,
    input  logic [N_GPIO-1:0]    gpio_ie_i,
    input  logic                 msg_valid_i,
    input  logic                 frame_end_i,
    output logic                 sleep_o,
    output logic                 listen_o,
    output logic [NUM_GATES-1:0] periph_en_o,
    output logic                 io_hold_o,
    output logic                 wake_o,
    output logic                 ack_sup_o
);
    sleep_state_e state;
    wake_src_t    src;
    logic         idle_done;
    logic         asleep;

    bus_sleep_idle_count #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .run       (state == ST_NORMAL),
        .tick      (bit_tick_i),
        .act       (bus_act_i),
        .limit_hit (idle_done)
    );

    bus_sleep_wake_merge #(.N_GPIO(N_GPIO)) u_wake (
        .ext_req (ext_wake_i),
        .bus_act (bus_act_i),
        .chg     (gpio_chg_i),
        .ie      (gpio_ie_i),
        .src     (src)
    );

    bus_sleep_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sleep_en    (sleep_en_i),
        .pu_sleep_en (pu_sleep_en_i),
        .tick        (bit_tick_i),
        .bus_act     (bus_act_i),
        .idle_done   (idle_done),
        .src         (src),
        .msg_valid   (msg_valid_i),
        .frame_end   (frame_end_i),
        .state       (state),
        .wake_pulse  (wake_o),
        .ack_sup     (ack_sup_o)
    );

    assign asleep    = (state == ST_SLEEP);
    assign sleep_o   = asleep;
    assign io_hold_o = asleep;
    assign listen_o  = (state == ST_LISTEN);

    for (genvar p = 0; p < NUM_GATES; p++) begin : g_gate
        assign periph_en_o[p] = !asleep;
    end

endmodule

// File: rtl/bus_sleep_checker.sv
module bus_sleep_checker #(
    parameter int N_GPIO = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep_en_i,
    input logic              bus_act_i,
    input logic              ext_wake_i,
    input logic [N_GPIO-1:0] gpio_chg_i,
    input logic [N_GPIO-1:0] gpio_ie_i,
    input logic              frame_end_i,
    input logic              sleep_o,
    input logic              listen_o,
    input logic [4:0]        periph_en_o,
    input logic              io_hold_o,
    input logic              wake_o,
    input logic              ack_sup_o
);
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> !wake_o); // R7

    AST_WAKE_AFTER_SLEEP: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (!sleep_o && $past(sleep_o))); // R7

    AST_NO_GATED_WAKE: assert property (@(posedge clk) disable iff (rst)
        (sleep_o && !ext_wake_i && !bus_act_i && ((gpio_chg_i & gpio_ie_i) == '0)) |=> sleep_o); // R8

    AST_ACK_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_sup_o) |-> ($past(bus_act_i) && wake_o)); // R9

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ack_sup_o && !frame_end_i) |=> ack_sup_o); // R9

    AST_HOLD_TRACKS: assert property (@(posedge clk) disable iff (rst)
        io_hold_o == sleep_o); // R10

    AST_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        sleep_o |-> (periph_en_o == 5'b00000)); // R11

    AST_SLEEP_ROUTE: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_o) |-> ($past(sleep_en_i) || $past(listen_o))); // R3

endmodule

bind bus_sleep_ctrl bus_sleep_checker #(.N_GPIO(N_GPIO)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sleep_en_i  (sleep_en_i),
    .bus_act_i   (bus_act_i),
    .ext_wake_i  (ext_wake_i),
    .gpio_chg_i  (gpio_chg_i),
    .gpio_ie_i   (gpio_ie_i),
    .frame_end_i (frame_end_i),
    .sleep_o     (sleep_o),
    .listen_o    (listen_o),
    .periph_en_o (periph_en_o),
    .io_hold_o   (io_hold_o),
    .wake_o      (wake_o),
    .ack_sup_o   (ack_sup_o)
);

// File: tb/bus_sleep_ctrl_test.sv
`timescale 1ns/1ps
module bus_sleep_ctrl_test;
    localparam int NG   = 8;
    localparam int IDLE = 1408;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_en = 1'b0, pu_en = 1'b0, tick = 1'b0, act = 1'b0, ext = 1'b0;
    logic [NG-1:0] chg = '0, ie = '0;
    logic mv = 1'b0, fe = 1'b0;
    logic sleep_w, listen_w, hold_w, wake_w, ack_w;
    logic [4:0] pen_w;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bus_sleep_ctrl #(.IDLE_BITS(IDLE), .N_GPIO(NG)) uut (
        .clk(clk), .rst(rst), .sleep_en_i(sleep_en), .pu_sleep_en_i(pu_en),
        .bit_tick_i(tick), .bus_act_i(act), .ext_wake_i(ext),
        .gpio_chg_i(chg), .gpio_ie_i(ie), .msg_valid_i(mv), .frame_end_i(fe),
        .sleep_o(sleep_w), .listen_o(listen_w), .periph_en_o(pen_w),
        .io_hold_o(hold_w), .wake_o(wake_w), .ack_sup_o(ack_w)
    );

    // reference model: 0 init, 1 normal, 2 listen, 3 sleep
    int m_mode = 0, m_idle = 0;
    bit m_armed = 0, m_from_pu = 0, m_ack = 0, m_wake = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_idle = 0; m_armed = 0; m_from_pu = 0; m_ack = 0; m_wake = 0;
        end else begin
            int nxt;
            bit woke;
            nxt  = m_mode;
            woke = ext || act || ((chg & ie) != '0);
            m_wake = 0;
            if (m_mode == 0) begin
                nxt = pu_en ? 2 : 1;
                m_armed = pu_en;
            end else if (m_mode == 1) begin
                if (act) m_idle = 0;
                else if (tick && m_idle < IDLE) m_idle++;
                if (sleep_en && !act && m_idle >= IDLE) nxt = 3;
            end else if (m_mode == 2) begin
                if (mv && !m_ack) begin nxt = 1; m_armed = 0; m_from_pu = 0; end
                else if (m_armed && act) m_armed = 0;
                else if (m_armed && tick) begin nxt = 3; m_armed = 0; m_from_pu = 1; end
            end else if (woke) begin
                m_wake = 1;
                nxt = m_from_pu ? 2 : 1;
            end
            if (m_mode == 3 && woke && act) m_ack = 1;
            else if (fe) m_ack = 0;
            if (nxt != 1) m_idle = 0;
            m_mode = nxt;
        end
    end

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 sleep_o model", sleep_w, m_mode == 3);
            chk("R5 listen_o model", listen_w, m_mode == 2);
            chk("R7 wake_o model", wake_w, m_wake);
            chk("R9 ack_sup_o model", ack_w, m_ack);
            chk("R10 io_hold_o model", hold_w, m_mode == 3);
            chk("R11 periph_en_o model", pen_w, (m_mode == 3) ? 0 : 31);
        end
    end

    task automatic idle(input int n);
        repeat (n) begin tick = 1'b1; @(negedge clk); end
        tick = 1'b0;
    endtask

    task automatic do_reset(input bit pu);
        rst = 1'b1; pu_en = pu;
        repeat (3) @(negedge clk);
        chk("R1 sleep", sleep_w, 0);
        chk("R1 listen", listen_w, 0);
        chk("R1 wake", wake_w, 0);
        chk("R1 ack", ack_w, 0);
        chk("R1 hold", hold_w, 0);
        chk("R1 periph", pen_w, 31);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        sleep_en = 1'b1;
        do_reset(1'b0);
        chk("R5 no pu sleep gives normal", listen_w, 0);
        idle(IDLE - 1);
        chk("R2 one strobe short", sleep_w, 0);
        act = 1'b1; @(negedge clk); act = 1'b0;
        idle(IDLE - 1);
        chk("R4 count restarted", sleep_w, 0);
        idle(1);
        chk("R2 sleep at limit", sleep_w, 1);
        chk("R10 hold in sleep", hold_w, 1);
        chk("R11 gates off", pen_w, 0);

        chg = 8'h10; ie = 8'hEF;
        repeat (3) @(negedge clk);
        chk("R8 disabled pin no wake", sleep_w, 1);
        ie = 8'h10; @(negedge clk); chg = '0; ie = '0;
        chk("R7 gpio wake pulse", wake_w, 1);
        chk("R7 gpio wake leaves sleep", sleep_w, 0);
        chk("R9 gpio wake no suppress", ack_w, 0);
        @(negedge clk);
        chk("R7 pulse single cycle", wake_w, 0);

        sleep_en = 1'b0;
        idle(IDLE + 100);
        chk("R3 disabled no sleep", sleep_w, 0);
        sleep_en = 1'b1; @(negedge clk);
        chk("R3 late enable sleeps", sleep_w, 1);

        act = 1'b1; @(negedge clk); act = 1'b0;
        chk("R7 bus wake pulse", wake_w, 1);
        chk("R9 bus wake suppress", ack_w, 1);
        repeat (5) @(negedge clk);
        chk("R9 suppress held", ack_w, 1);
        fe = 1'b1; @(negedge clk); fe = 1'b0;
        chk("R9 cleared at frame end", ack_w, 0);

        idle(IDLE);
        chk("R2 sleep again", sleep_w, 1);
        ext = 1'b1; @(negedge clk); ext = 1'b0;
        chk("R7 external wake", wake_w, 1);
        chk("R9 external no suppress", ack_w, 0);

        do_reset(1'b1);
        chk("R5 listen after reset", listen_w, 1);
        idle(1);
        chk("R5 power-up sleep", sleep_w, 1);
        act = 1'b1; @(negedge clk); act = 1'b0;
        chk("R6 back to listen", listen_w, 1);
        chk("R9 bus wake suppress pu", ack_w, 1);
        mv = 1'b1; @(negedge clk); mv = 1'b0;
        chk("R6 waking frame ignored", listen_w, 1);
        fe = 1'b1; @(negedge clk); fe = 1'b0;
        idle(3);
        chk("R6 no resleep in listen", sleep_w, 0);
        mv = 1'b1; @(negedge clk); mv = 1'b0;
        chk("R6 valid message to normal", listen_w, 0);

        do_reset(1'b1);
        act = 1'b1; @(negedge clk); act = 1'b0;
        idle(10);
        chk("R12 activity cancels pu sleep", sleep_w, 0);
        chk("R12 stays listen", listen_w, 1);
        mv = 1'b1; @(negedge clk); mv = 1'b0;
        chk("R6 normal after message", listen_w, 0);

        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule